// File: doc/BRIEF.md
# Windowed Code-Block Sync Tracker

This block follows a stream of hard-decision marker correlation results, one per received bit, and keeps the receiver aligned to fixed-length coded blocks. Each block is 6400 bits long. It holds 6144 code-word bits and then a 256-bit sync marker. The correlation score for a bit is the agreement count of the marker window that ends on that bit. While searching, the tracker acquires on the first bit whose score reaches the programmable threshold. It also captures the phase hypothesis that the correlator reports with that bit.

Once locked, the tracker looks only at the score on the bit where the next marker is due to end. It keeps a running sum of the last four such scores. Lock is kept while that sum stays at or above four times the threshold. At acquisition the window is filled with the acquiring score, so the first blocks after lock lean on that value until real history arrives. When lock is lost, the window is cleared and the search starts again on the very next bit. Downstream logic uses the code-word start strobe to frame blocks. It uses the strip enable to discard marker bits, so that only code-word bits reach the decoder.

Top module: `blk_sync_track`

## Requirements
- R1: After reset, `locked`, `cw_start` and `mark_strip` are 0 and `phase_hold` is 0.
- R2: While unlocked, a valid bit whose score is greater than or equal to `thr_cfg` sets `locked` from the next cycle. A score of `thr_cfg`-1 or lower leaves the tracker unlocked.
- R3: `phase_hold` takes the `in_phase` value of the acquiring bit. It stays unchanged while locked, whatever `in_phase` does, and changes only at a later acquisition.
- R4: While locked, bit positions count valid bits only, with position 0 being the first bit after the acquiring or marker-ending bit. `cw_start` is high on a valid bit at position 0. Bits with `in_valid` low do not advance the position.
- R5: While locked, `mark_strip` is high on valid bits at positions 6144 through 6399 (the marker bits) and low on code-word bits.
- R6: While locked, scores on every valid bit other than position 6399 are ignored, including scores above the threshold.
- R7: At position 6399 the score enters a four-entry window whose entries all hold the acquiring score right after acquisition. Lock is kept when the new window sum is at least 4 × `thr_cfg`, with equality keeping lock.
- R8: When the window sum falls below 4 × `thr_cfg`, `locked` drops on the next cycle and the window is emptied. No strobes are produced while unlocked. Acquisition is possible again from the very next valid bit, at any bit position.
- R9: The threshold is taken from `thr_cfg` (nominally 192), and both the acquisition and the hold tests follow a changed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A received bit and its score are present this cycle |
| in_score | input | 9 | Marker agreement count for the window ending on this bit |
| in_phase | input | 2 | Phase hypothesis that produced the score |
| thr_cfg | input | 9 | Correlation threshold |
| locked | output | 1 | Block synchronization held |
| cw_start | output | 1 | This valid bit is the first code-word bit of a block |
| mark_strip | output | 1 | This valid bit is a marker bit and is to be dropped |
| phase_hold | output | 2 | Phase hypothesis frozen at acquisition |

## Verification
Noise below the threshold, with single scores at exactly the threshold and one below it, separates the acquisition compare from an off-by-one. Marker scores held at the threshold and then dropped by one, and a clean lock followed by zero-score markers, show the equality case and prove that the window is prefilled and averaged rather than judged per block. Large scores placed away from the marker position, plus idle bits mixed into locked runs, tell a tracker that looks only at the expected position apart from one that reacts anywhere or counts idle cycles. Randomized rounds with changing thresholds, gaps and spurious peaks compare every output on every bit against a bench model.

// File: rtl/blk_sync_pkg.sv
package blk_sync_pkg;

  // Tracker operating state
  typedef enum logic {
    TRK_SEARCH = 1'b0,
    TRK_LOCKED = 1'b1
  } trk_state_e;

endpackage

// File: rtl/blk_pos_ctr.sv
module blk_pos_ctr #(
  parameter int unsigned BLK_BITS  = 6400,
  parameter int unsigned MARK_BITS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,      // restart at position 0
  input  logic adv,       // one valid locked bit consumed
  output logic at_first,
  output logic at_last,
  output logic in_mark
);
  localparam int unsigned POS_W   = $clog2(BLK_BITS);
  localparam int unsigned CW_BITS = BLK_BITS - MARK_BITS;
  localparam int unsigned LAST    = BLK_BITS - 1;

  logic [POS_W-1:0] pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pos <= '0;
    else if (load)     pos <= '0;
    else if (adv)      pos <= (pos == POS_W'(LAST)) ? '0 : pos + 1'b1;
  end

  assign at_first = (pos == '0);
  assign at_last  = (pos == POS_W'(LAST));
  assign in_mark  = (pos >= POS_W'(CW_BITS));

  // R4
  pos_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(pos));

  // R4
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= POS_W'(LAST));

endmodule

// File: rtl/score_window.sv
module score_window #(
  parameter int unsigned SCORE_W = 9,
  parameter int unsigned WIN     = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                clear,
  input  logic                                fill,
  input  logic                                push,
  input  logic [SCORE_W-1:0]                  val,
  output logic [SCORE_W+$clog2(WIN)-1:0]      sum,
  output logic [SCORE_W+$clog2(WIN)-1:0]      next_sum
);
  localparam int unsigned SUM_W = SCORE_W + $clog2(WIN);

  logic [WIN-1:0][SCORE_W-1:0] slot;

  // Window total when every entry holds the same score
  function automatic logic [SUM_W-1:0] fill_total(input logic [SCORE_W-1:0] v);
    return SUM_W'(v) * SUM_W'(WIN);
  endfunction

  // Running sum after the oldest entry leaves and v enters
  function automatic logic [SUM_W-1:0] slide_total(input logic [SUM_W-1:0] s,
                                                   input logic [SCORE_W-1:0] v,
                                                   input logic [SCORE_W-1:0] oldest);
    return s + SUM_W'(v) - SUM_W'(oldest);
  endfunction

  assign next_sum = slide_total(sum, val, slot[WIN-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
      sum  <= '0;
    end else if (clear) begin
      slot <= '0;
      sum  <= '0;
    end else if (fill) begin
      for (int i = 0; i < WIN; i++) slot[i] <= val;
      sum <= fill_total(val);
    end else if (push) begin
      for (int i = WIN - 1; i > 0; i--) slot[i] <= slot[i-1];
      slot[0] <= val;
      sum     <= next_sum;
    end
  end

  // R7
  win_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill && !clear) |=> (slot[WIN-1] == $past(val)));

endmodule

// File: rtl/blk_sync_track.sv
module blk_sync_track #(
  parameter int unsigned BLK_BITS  = 6400,
  parameter int unsigned MARK_BITS = 256,
  parameter int unsigned SCORE_W   = 9,
  parameter int unsigned WIN       = 4,
  parameter int unsigned PH_W      = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [SCORE_W-1:0] in_score,
  input  logic [PH_W-1:0]    in_phase,
  input  logic [SCORE_W-1:0] thr_cfg,
  output logic               locked,
  output logic               cw_start,
  output logic               mark_strip,
  output logic [PH_W-1:0]    phase_hold
);
  import blk_sync_pkg::*;

  localparam int unsigned SUM_W = SCORE_W + $clog2(WIN);

  trk_state_e       state;
  logic             at_first, at_last, in_mark;
  logic [SUM_W-1:0] win_sum, win_next;

  // Named internal events
  logic acq_evt, mark_evt, keep_ok, lose_evt;

  // Hold test: window sum against WIN times the threshold
  function automatic logic sum_meets(input logic [SUM_W-1:0] s,
                                     input logic [SCORE_W-1:0] thr);
    return s >= (SUM_W'(thr) * SUM_W'(WIN));
  endfunction

  assign acq_evt  = (state == TRK_SEARCH) && in_valid && (in_score >= thr_cfg);
  assign mark_evt = (state == TRK_LOCKED) && in_valid && at_last;
  assign keep_ok  = sum_meets(win_next, thr_cfg);
  assign lose_evt = mark_evt && !keep_ok;

  blk_pos_ctr #(
    .BLK_BITS  (BLK_BITS),
    .MARK_BITS (MARK_BITS)
  ) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (acq_evt),
    .adv      ((state == TRK_LOCKED) && in_valid),
    .at_first (at_first),
    .at_last  (at_last),
    .in_mark  (in_mark)
  );

  score_window #(
    .SCORE_W (SCORE_W),
    .WIN     (WIN)
  ) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (lose_evt),
    .fill     (acq_evt),
    .push     (mark_evt),
    .val      (in_score),
    .sum      (win_sum),
    .next_sum (win_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= TRK_SEARCH;
      phase_hold <= '0;
    end else if (acq_evt) begin
      state      <= TRK_LOCKED;
      phase_hold <= in_phase;
    end else if (lose_evt) begin
      state      <= TRK_SEARCH;
    end
  end

  assign locked     = (state == TRK_LOCKED);
  assign cw_start   = locked && in_valid && at_first;
  assign mark_strip = locked && in_valid && in_mark;

  // R2
  acq_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_evt |=> (locked && phase_hold == $past(in_phase)));

  // R3
  phase_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !lose_evt) |=> $stable(phase_hold));

  // R5
  mark_strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark_evt |-> mark_strip);

  // R6
  off_pos_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !mark_evt) |=> ($stable(win_sum) && locked));

  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_evt && keep_ok) |=> locked);

  // R8
  lose_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lose_evt |=> (!locked && win_sum == '0));

endmodule

// File: tb/test_blk_sync_track.sv
module test_blk_sync_track;
  localparam int BLK  = 64;
  localparam int MK   = 16;
  localparam int CW   = BLK - MK;
  localparam int LAST = BLK - 1;
  localparam int WINN = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [8:0] in_score = '0;
  logic [1:0] in_phase = '0;
  logic [8:0] thr_cfg = 9'd192;
  logic       locked, cw_start, mark_strip;
  logic [1:0] phase_hold;

  always #4 clk = ~clk;

  blk_sync_track #(.BLK_BITS(BLK), .MARK_BITS(MK), .SCORE_W(9), .WIN(WINN), .PH_W(2))
  i_blk_sync_track (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_score(in_score),
    .in_phase(in_phase), .thr_cfg(thr_cfg), .locked(locked), .cw_start(cw_start),
    .mark_strip(mark_strip), .phase_hold(phase_hold)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  int thr = 192;

  // Bench model
  bit m_lock = 0;
  int m_pos = 0;
  int m_phase = 0;
  int m_win[WINN];

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int win_total();
    int s = 0;
    for (int i = 0; i < WINN; i++) s += m_win[i];
    return s;
  endfunction

  task automatic model_bit(input int s, input int ph, input bit v);
    if (!v) return;
    if (!m_lock) begin
      if (s >= thr) begin
        m_lock = 1; m_pos = 0; m_phase = ph;
        for (int i = 0; i < WINN; i++) m_win[i] = s;
      end
    end else if (m_pos == LAST) begin
      for (int i = WINN - 1; i > 0; i--) m_win[i] = m_win[i-1];
      m_win[0] = s;
      m_pos = 0;
      if (win_total() < WINN * thr) begin
        m_lock = 0;
        for (int i = 0; i < WINN; i++) m_win[i] = 0;
      end
    end else begin
      m_pos++;
    end
  endtask

  task automatic step(input int s, input int ph, input bit v);
    @(negedge clk);
    in_valid = v; in_score = 9'(s); in_phase = 2'(ph); thr_cfg = 9'(thr);
    #1;
    check("R7 lock", int'(locked), int'(m_lock));
    check("R4 cw_start", int'(cw_start), int'(m_lock && v && m_pos == 0));
    check("R5 strip", int'(mark_strip), int'(m_lock && v && m_pos >= CW));
    check("R3 phase", int'(phase_hold), m_phase);
    model_bit(s, ph, v);
  endtask

  task automatic after_edge();
    @(posedge clk); #1;
  endtask

  // Run to the marker-ending bit with large off-position scores, then score it
  task automatic to_mark(input int val);
    if (!m_lock) return;
    while (m_pos != LAST)
      step($urandom_range(0, 511), $urandom_range(0, 3), $urandom_range(0, 99) < 85);
    step(val, $urandom_range(0, 3), 1);
    after_edge();
  endtask

  initial begin
    void'($urandom(32'h5A17));
    for (int i = 0; i < WINN; i++) m_win[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1
    check("R1 lock", int'(locked), 0);
    check("R1 cw_start", int'(cw_start), 0);
    check("R1 strip", int'(mark_strip), 0);
    check("R1 phase", int'(phase_hold), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: noise below threshold, then exact boundaries
    for (int i = 0; i < 200; i++) step($urandom_range(0, thr - 1), $urandom_range(0, 3), 1);
    step(thr - 1, 3, 1); after_edge();
    check("R2 below thr", int'(locked), 0);
    step(thr, 2, 1); after_edge();
    check("R2 at thr", int'(locked), 1);
    check("R3 captured", int'(phase_hold), 2);

    // R7: equality keeps lock, one short loses it
    for (int k = 0; k < 3; k++) begin
      to_mark(thr); check("R7 equal sum", int'(locked), 1);
    end
    to_mark(thr - 1);
    check("R8 lost", int'(locked), 0);
    check("R8 no strip", int'(mark_strip), 0);

    // R8: reacquire a few bits later at an arbitrary position
    for (int i = 0; i < 5; i++) step($urandom_range(0, 100), 0, 1);
    step(256, 1, 1); after_edge();
    check("R8 reacquire", int'(locked), 1);
    check("R3 updated", int'(phase_hold), 1);

    // R7 prefill: one zero marker tolerated, second drops lock
    to_mark(0); check("R7 prefill hold", int'(locked), 1);
    to_mark(0); check("R7 average drop", int'(locked), 0);

    // R6: a high score off position is ignored; prefill 200 then 168 equals 768
    step(200, 0, 1);
    to_mark(168); check("R6 R7 kept", int'(locked), 1);
    to_mark(0); check("R7 drop", int'(locked), 0);

    // R9: changed threshold
    thr = 100;
    step(99, 2, 1); after_edge(); check("R9 below", int'(locked), 0);
    step(100, 3, 1); after_edge(); check("R9 at", int'(locked), 1);
    to_mark(100); check("R9 hold", int'(locked), 1);
    to_mark(99); check("R9 lose", int'(locked), 0);

    // Randomized rounds
    for (int r = 0; r < 8; r++) begin
      thr = $urandom_range(150, 220);
      for (int b = 0; b < 12 * BLK; b++) begin
        int s;
        bit v;
        v = $urandom_range(0, 99) < 85;
        if (m_lock && m_pos == LAST)      s = $urandom_range(thr - 30, 256);
        else if (m_lock)                  s = $urandom_range(0, 511);
        else if ($urandom_range(0, 99) < 3) s = $urandom_range(thr, 256);
        else                              s = $urandom_range(0, thr - 1);
        step(s, $urandom_range(0, 3), v);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete (R1..all)");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule